// File: doc/BRIEF.md
# Role-Decoded Integer Register File

This block is the integer register store of a 64-bit execution core. It keeps thirty-one general registers at indices 0 to 30 and one stack-pointer register that lives apart from them. The top index value, 31, owns no storage. What it means depends on the role bit sent with the operand. In base-address role it reaches the stack pointer. In arithmetic or destination role it is a hard zero: reads return zero and writes are dropped.

There are two combinational read ports and one write port. Every port carries a size bit. A 32-bit write keeps the low half of the data and clears the upper half, and this applies to the stack pointer too. A 32-bit read returns the low half with the upper half cleared. A separate strobe loads a return address into register 30, which serves as the link register. A read that names a location being written in the same cycle sees the new value.

When alignment enforcement is on, a base-role use of the stack pointer whose value is not a multiple of 16 bytes is refused. The port that made the access returns zero, and a one-cycle fault pulse follows on the next cycle.

Top module: `rf_ctx_regfile`

## Requirements
- R1: A 64-bit write (size bit 0) to index 0..30 stores the full data word. A later 64-bit read of that index returns it unchanged, whatever the read role bit is.
- R2: Index 31 in arithmetic role (role bit 0) reads as zero. A write to index 31 in arithmetic role changes no register and does not change the stack pointer.
- R3: Index 31 in base role (role bit 1) reads and writes the stack pointer. The stack pointer is a register of its own, apart from indices 0..30.
- R4: A 32-bit write (size bit 1) stores data bits 31:0 and clears bits 63:32. This holds for the stack pointer as well.
- R5: A 32-bit read (size bit 1) returns bits 31:0 of the location, with bits 63:32 zero.
- R6: A read of a location that is being written in the same cycle returns the value that location will hold after the clock edge. This covers the stack pointer and the link strobe.
- R7: The link strobe loads its 64-bit address into register 30 at the clock edge. If the write port targets register 30 in the same cycle, the write port's value is stored instead.
- R8: With enforcement on, a base-role read of index 31 while the stack pointer bits 3:0 are not all zero returns zero on that port. `align_fault` is then high for exactly the next cycle.
- R9: No fault is raised when enforcement is off, when the stack pointer bits 3:0 are all zero, or when index 31 is used in arithmetic role. With enforcement off, the misaligned stack pointer reads normally.
- R10: Reset clears all 31 registers and the stack pointer to zero and holds `align_fault` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write index |
| wr_w32 | input | 1 | Write size: 1 = 32-bit, 0 = 64-bit |
| wr_base | input | 1 | Write role: 1 = base address, 0 = arithmetic/destination |
| wr_data | input | 64 | Write data |
| lnk_en | input | 1 | Link strobe for register 30 |
| lnk_addr | input | 64 | Return address loaded by the link strobe |
| align_en | input | 1 | Stack alignment enforcement enable |
| rd0_idx | input | 5 | Read port 0 index |
| rd0_w32 | input | 1 | Read port 0 size: 1 = 32-bit |
| rd0_base | input | 1 | Read port 0 role: 1 = base address |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 5 | Read port 1 index |
| rd1_w32 | input | 1 | Read port 1 size: 1 = 32-bit |
| rd1_base | input | 1 | Read port 1 role: 1 = base address |
| rd1_data | output | 64 | Read port 1 data |
| align_fault | output | 1 | One-cycle pulse after a refused stack access |

## Verification
A corrupted register or stack-pointer value shows up on the read data in the same cycle it is named, because the ports are combinational. Through the bypass, it shows up even in the cycle of the faulty write. A wrong decode of index 31 appears at once, as a nonzero arithmetic-role read or a stack pointer that moved after a dropped write. A wrong alignment decision shows one cycle later on `align_fault`, and in the same cycle as non-zero data on the refused port.

// File: rtl/rf_ctx_pkg.sv
package rf_ctx_pkg;
  localparam int XLEN     = 64;
  localparam int HALF     = XLEN / 2;
  localparam int IDXW     = 5;
  localparam int NSLOT    = 1 << IDXW;
  localparam int NGPR     = NSLOT - 1;
  localparam int LINK_IDX = NGPR - 1;
  localparam int SP_IDX   = NSLOT - 1;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [IDXW-1:0] idx_t;

  // Keep the low half and clear the upper half when the narrow size is selected.
  function automatic word_t narrow(input word_t v, input logic w32);
    narrow = w32 ? {{HALF{1'b0}}, v[HALF-1:0]} : v;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import rf_ctx_pkg::*;
(
  input  logic                  wr_en,
  input  idx_t                  wr_idx,
  input  logic                  wr_w32,
  input  logic                  wr_base,
  input  word_t                 wr_data,
  input  logic                  lnk_en,
  input  word_t                 lnk_addr,
  output logic [NSLOT-1:0]      slot_we,
  output logic [NSLOT-1:0][XLEN-1:0] slot_wd
);
  word_t port_val;
  logic  port_hits_link;

  always_comb begin
    port_val       = narrow(wr_data, wr_w32);
    port_hits_link = wr_en && (wr_idx == idx_t'(LINK_IDX));
    for (int i = 0; i < NSLOT; i++) begin
      slot_wd[i] = port_val;
      slot_we[i] = wr_en && (wr_idx == idx_t'(i));
    end
    // Link register: the write port has priority over the link strobe.
    slot_we[LINK_IDX] = port_hits_link || lnk_en;
    slot_wd[LINK_IDX] = port_hits_link ? port_val : lnk_addr;
    // Slot 31 is the stack pointer, reachable only in base role.
    slot_we[SP_IDX]   = wr_en && wr_base && (wr_idx == idx_t'(SP_IDX));
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_ctx_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSLOT-1:0]           slot_we,
  input  logic [NSLOT-1:0][XLEN-1:0] slot_wd,
  output logic [NSLOT-1:0][XLEN-1:0] slot_q
);
  // Slots 0..30 are general registers; slot 31 is the stack pointer.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    word_t q;
    word_t d;

    always_comb d = slot_wd[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (slot_we[g]) q <= d;
    end

    assign slot_q[g] = q;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_ctx_pkg::*;
#(
  parameter int ALIGN_LSB = 4
) (
  input  idx_t                       rd_idx,
  input  logic                       rd_w32,
  input  logic                       rd_base,
  input  logic                       align_en,
  input  logic [NSLOT-1:0][XLEN-1:0] slot_q,
  input  logic [NSLOT-1:0]           slot_we,
  input  logic [NSLOT-1:0][XLEN-1:0] slot_wd,
  output word_t                      rd_data,
  output logic                       fault
);
  word_t cur;
  word_t val;
  logic  sel_top;
  logic  hard_zero;

  always_comb begin
    cur       = slot_we[rd_idx] ? slot_wd[rd_idx] : slot_q[rd_idx];
    sel_top   = (rd_idx == idx_t'(SP_IDX));
    hard_zero = sel_top && !rd_base;
    fault     = align_en && sel_top && rd_base && (|cur[ALIGN_LSB-1:0]);
    val       = (hard_zero || fault) ? '0 : cur;
    rd_data   = narrow(val, rd_w32);
  end
endmodule

// File: rtl/rf_ctx_regfile.sv
module rf_ctx_regfile
  import rf_ctx_pkg::*;
#(
  parameter int ALIGN_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic        wr_w32,
  input  logic        wr_base,
  input  logic [63:0] wr_data,
  input  logic        lnk_en,
  input  logic [63:0] lnk_addr,
  input  logic        align_en,
  input  logic [4:0]  rd0_idx,
  input  logic        rd0_w32,
  input  logic        rd0_base,
  output logic [63:0] rd0_data,
  input  logic [4:0]  rd1_idx,
  input  logic        rd1_w32,
  input  logic        rd1_base,
  output logic [63:0] rd1_data,
  output logic        align_fault
);
  localparam int ALIGN_LSB = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1;
  localparam int NRD       = 2;

  logic [NSLOT-1:0]           slot_we;
  logic [NSLOT-1:0][XLEN-1:0] slot_wd;
  logic [NSLOT-1:0][XLEN-1:0] slot_q;

  logic [NRD-1:0][IDXW-1:0] rq_idx;
  logic [NRD-1:0]           rq_w32;
  logic [NRD-1:0]           rq_base;
  logic [NRD-1:0][XLEN-1:0] rq_data;
  logic [NRD-1:0]           rq_fault;

  logic fault_d;
  logic fault_q;

  rf_wr_decode u_dec (
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_w32   (wr_w32),
    .wr_base  (wr_base),
    .wr_data  (wr_data),
    .lnk_en   (lnk_en),
    .lnk_addr (lnk_addr),
    .slot_we  (slot_we),
    .slot_wd  (slot_wd)
  );

  rf_storage u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_we (slot_we),
    .slot_wd (slot_wd),
    .slot_q  (slot_q)
  );

  assign rq_idx  = {rd1_idx,  rd0_idx};
  assign rq_w32  = {rd1_w32,  rd0_w32};
  assign rq_base = {rd1_base, rd0_base};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_read_port #(.ALIGN_LSB(ALIGN_LSB)) u_port (
      .rd_idx   (rq_idx[p]),
      .rd_w32   (rq_w32[p]),
      .rd_base  (rq_base[p]),
      .align_en (align_en),
      .slot_q   (slot_q),
      .slot_we  (slot_we),
      .slot_wd  (slot_wd),
      .rd_data  (rq_data[p]),
      .fault    (rq_fault[p])
    );
  end

  assign rd0_data = rq_data[0];
  assign rd1_data = rq_data[1];

  always_comb fault_d = |rq_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign align_fault = fault_q;
endmodule

// File: rtl/rf_ctx_chk.sv
module rf_ctx_chk #(
  parameter int ALIGN_LSB = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        align_en,
  input logic [4:0]  rd0_idx,
  input logic        rd0_w32,
  input logic        rd0_base,
  input logic [63:0] rd0_data,
  input logic [4:0]  rd1_idx,
  input logic        rd1_w32,
  input logic        rd1_base,
  input logic [63:0] rd1_data,
  input logic        align_fault
);
  a_r2_zero_port0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx == 5'd31 && !rd0_base) |-> rd0_data == 64'd0);

  a_r2_zero_port1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_idx == 5'd31 && !rd1_base) |-> rd1_data == 64'd0);

  a_r5_narrow_port0: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_w32 |-> rd0_data[63:32] == 32'd0);

  a_r5_narrow_port1: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_w32 |-> rd1_data[63:32] == 32'd0);

  a_r8_no_misaligned_sp0: assert property (@(posedge clk) disable iff (!rst_n)
    (align_en && rd0_idx == 5'd31 && rd0_base) |-> rd0_data[ALIGN_LSB-1:0] == '0);

  a_r8_no_misaligned_sp1: assert property (@(posedge clk) disable iff (!rst_n)
    (align_en && rd1_idx == 5'd31 && rd1_base) |-> rd1_data[ALIGN_LSB-1:0] == '0);

  a_r8_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> ($past(align_en) &&
                     ($past(rd0_idx == 5'd31 && rd0_base) ||
                      $past(rd1_idx == 5'd31 && rd1_base))));

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !align_en |=> !align_fault);
endmodule

bind rf_ctx_regfile rf_ctx_chk u_chk (.*);

// File: tb/rf_ctx_regfile_bench.sv
module rf_ctx_regfile_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic        wr_w32;
  logic        wr_base;
  logic [63:0] wr_data;
  logic        lnk_en;
  logic [63:0] lnk_addr;
  logic        align_en;
  logic [4:0]  rd0_idx;
  logic        rd0_w32;
  logic        rd0_base;
  logic [63:0] rd0_data;
  logic [4:0]  rd1_idx;
  logic        rd1_w32;
  logic        rd1_base;
  logic [63:0] rd1_data;
  logic        align_fault;

  int n_chk = 0;
  int n_bad = 0;

  rf_ctx_regfile u_rf_ctx_regfile (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [4:0]  wi;
    logic        ww;
    logic        wb;
    logic [63:0] wd;
    logic [4:0]  a0;
    logic        s0;
    logic        b0;
    logic [63:0] e0;
    logic [4:0]  a1;
    logic        s1;
    logic        b1;
    logic [63:0] e1;
  } vec_t;

  // Role bit 1 = base address, 0 = arithmetic/destination. Size bit 1 = 32-bit.
  localparam vec_t VEC [9] = '{
    '{1'b1, 5'd3,  1'b0, 1'b0, 64'h1122334455667788,
      5'd3,  1'b0, 1'b0, 64'h1122334455667788,
      5'd3,  1'b1, 1'b0, 64'h0000000055667788},
    '{1'b1, 5'd3,  1'b1, 1'b0, 64'hFFFFFFFFAABBCCDD,
      5'd3,  1'b0, 1'b0, 64'h00000000AABBCCDD,
      5'd5,  1'b0, 1'b0, 64'h0},
    '{1'b1, 5'd31, 1'b0, 1'b0, 64'hDEADBEEFDEADBEEF,
      5'd31, 1'b0, 1'b0, 64'h0,
      5'd31, 1'b0, 1'b1, 64'h0},
    '{1'b1, 5'd31, 1'b0, 1'b1, 64'h0000000000001000,
      5'd31, 1'b0, 1'b1, 64'h0000000000001000,
      5'd3,  1'b0, 1'b0, 64'h00000000AABBCCDD},
    '{1'b0, 5'd0,  1'b0, 1'b0, 64'h0,
      5'd31, 1'b0, 1'b1, 64'h0000000000001000,
      5'd31, 1'b0, 1'b0, 64'h0},
    '{1'b1, 5'd31, 1'b1, 1'b1, 64'hFFFFFFFF80000010,
      5'd31, 1'b0, 1'b1, 64'h0000000080000010,
      5'd30, 1'b0, 1'b0, 64'h0},
    '{1'b1, 5'd0,  1'b0, 1'b0, 64'h0123456789ABCDEF,
      5'd0,  1'b0, 1'b0, 64'h0123456789ABCDEF,
      5'd0,  1'b1, 1'b0, 64'h0000000089ABCDEF},
    '{1'b1, 5'd30, 1'b0, 1'b1, 64'hCAFEF00D12345678,
      5'd30, 1'b0, 1'b1, 64'hCAFEF00D12345678,
      5'd0,  1'b0, 1'b1, 64'h0123456789ABCDEF},
    '{1'b0, 5'd0,  1'b0, 1'b0, 64'h0,
      5'd31, 1'b1, 1'b1, 64'h0000000080000010,
      5'd3,  1'b0, 1'b1, 64'h00000000AABBCCDD}
  };

  string ROWTAG [9] = '{"R1 R6 R5", "R4 R6", "R2", "R3 R6", "R3 R2",
                        "R4 R3", "R1 R5", "R1 R6", "R5 R3 R1"};

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drv(input logic we, input logic [4:0] wi, input logic ww,
                     input logic wb, input logic [63:0] wd,
                     input logic le, input logic [63:0] la, input logic ae,
                     input logic [4:0] a0, input logic s0, input logic b0,
                     input logic [4:0] a1, input logic s1, input logic b1);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_w32 = ww; wr_base = wb; wr_data = wd;
    lnk_en = le; lnk_addr = la; align_en = ae;
    rd0_idx = a0; rd0_w32 = s0; rd0_base = b0;
    rd1_idx = a1; rd1_w32 = s1; rd1_base = b1;
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_idx = 0; wr_w32 = 0; wr_base = 0; wr_data = 0;
    lnk_en = 0; lnk_addr = 0; align_en = 0;
    rd0_idx = 5'd0; rd0_w32 = 0; rd0_base = 0;
    rd1_idx = 5'd31; rd1_w32 = 0; rd1_base = 1;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "x0 in reset", rd0_data, 64'h0);
    chk("R10", "sp in reset", rd1_data, 64'h0);
    chk("R10", "fault in reset", {63'd0, align_fault}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      drv(VEC[i].we, VEC[i].wi, VEC[i].ww, VEC[i].wb, VEC[i].wd,
          1'b0, 64'h0, 1'b0,
          VEC[i].a0, VEC[i].s0, VEC[i].b0, VEC[i].a1, VEC[i].s1, VEC[i].b1);
      chk(ROWTAG[i], $sformatf("row %0d port0", i), rd0_data, VEC[i].e0);
      chk(ROWTAG[i], $sformatf("row %0d port1", i), rd1_data, VEC[i].e1);
    end

    // R7: link strobe together with a write elsewhere, bypassed read
    drv(1, 5'd5, 0, 0, 64'h55, 1, 64'h00007FFF00004444, 0,
        5'd30, 0, 0, 5'd5, 0, 0);
    chk("R7", "link bypass", rd0_data, 64'h00007FFF00004444);
    chk("R6", "x5 bypass", rd1_data, 64'h55);
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 0, 5'd30, 0, 0, 5'd5, 0, 0);
    chk("R7", "link stored", rd0_data, 64'h00007FFF00004444);
    chk("R1", "x5 stored", rd1_data, 64'h55);

    // R7: write port beats link strobe on register 30
    drv(1, 5'd30, 0, 0, 64'h2222, 1, 64'h1111, 0, 5'd30, 0, 0, 5'd0, 0, 0);
    chk("R7", "conflict bypass", rd0_data, 64'h2222);
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 0, 5'd30, 0, 0, 5'd0, 0, 0);
    chk("R7", "conflict stored", rd0_data, 64'h2222);

    // R8: misaligned stack pointer in base role with enforcement on
    drv(1, 5'd31, 0, 1, 64'h1008, 0, 64'h0, 0, 5'd0, 0, 0, 5'd0, 0, 0);
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 1, 5'd31, 0, 1, 5'd31, 0, 0);
    chk("R8", "refused read", rd0_data, 64'h0);
    chk("R2", "arith 31 with enforcement", rd1_data, 64'h0);
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 0, 5'd31, 0, 1, 5'd0, 0, 0);
    chk("R8", "fault pulse", {63'd0, align_fault}, 64'h1);
    chk("R9", "misaligned read unenforced", rd0_data, 64'h1008);
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 0, 5'd0, 0, 0, 5'd0, 0, 0);
    chk("R8", "fault one cycle", {63'd0, align_fault}, 64'h0);

    // R9: arithmetic-role index 31 never faults
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 1, 5'd31, 0, 0, 5'd3, 0, 1);
    chk("R1", "x3 base role", rd1_data, 64'h00000000AABBCCDD);
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 0, 5'd0, 0, 0, 5'd0, 0, 0);
    chk("R9", "no fault arith role", {63'd0, align_fault}, 64'h0);

    // R9: aligned value arriving through the bypass
    drv(1, 5'd31, 0, 1, 64'h2000, 0, 64'h0, 1, 5'd31, 0, 1, 5'd0, 0, 0);
    chk("R6", "aligned sp bypass", rd0_data, 64'h2000);
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 0, 5'd0, 0, 0, 5'd0, 0, 0);
    chk("R9", "no fault aligned", {63'd0, align_fault}, 64'h0);

    // R8 on port 1 with a narrow misaligned stack write
    drv(1, 5'd31, 1, 1, 64'hFFFFFFFF00002004, 0, 64'h0, 1,
        5'd0, 0, 0, 5'd31, 0, 1);
    chk("R8", "port1 refused", rd1_data, 64'h0);
    drv(0, 5'd0, 0, 0, 64'h0, 0, 64'h0, 0, 5'd31, 0, 1, 5'd0, 0, 0);
    chk("R8", "port1 fault pulse", {63'd0, align_fault}, 64'h1);
    chk("R4", "sp narrow write", rd0_data, 64'h0000000000002004);

    // R10: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    rd0_idx = 5'd30; rd0_w32 = 0; rd0_base = 0;
    rd1_idx = 5'd31; rd1_w32 = 0; rd1_base = 1;
    #1;
    chk("R10", "x30 after reset", rd0_data, 64'h0);
    chk("R10", "sp after reset", rd1_data, 64'h0);
    rd0_idx = 5'd3;
    #1;
    chk("R10", "x3 after reset", rd0_data, 64'h0);
    chk("R10", "fault after reset", {63'd0, align_fault}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule